// File: doc/BRIEF.md
# Multi-CPU Auto-Masking Interrupt Controller

This block gathers a set of level-sensitive interrupt lines and hands them to several processors, one at a time. Each source is pending while its hardware line or its software-trigger bit is high. It also carries a mask bit and a routing bitmask that selects the processors allowed to take it. Software reaches the mask, trigger and routing state through a word-addressed register port. Each processor has a dedicated acknowledge strobe and event word, plus a level interrupt output.

When a processor pulses its acknowledge strobe, the block returns the lowest-numbered source that is pending, unmasked and routed to that processor. At the same clock edge it sets that source's mask bit, so the source cannot be delivered twice. Software clears the mask after servicing the source to arm it again. There are no priority registers: a lower source number always wins.

Top module: `irqc_ctrl`

Word addresses, with W = NUM_SRC/32: routing words at 0 to NUM_SRC-1. The arrays follow in a fixed order, each W words long, starting at NUM_SRC: trigger-set, trigger-clear, mask-set, mask-clear, line-state. With the defaults these are 64, 66, 68, 70 and 72. Bit b of array word k refers to source 32k+b.

## Requirements
- R1: A source is pending exactly while its hardware line OR its software-trigger bit is 1. When both are 0 it stops being reported.
- R2: Writing 1s to a mask-set word (base NUM_SRC+2W) sets those mask bits, and writing 1s to a mask-clear word (base NUM_SRC+3W) clears them. Zero bits have no effect. Reading either word returns the current mask bits.
- R3: Writing 1s to a trigger-set word (base NUM_SRC) sets those software-trigger bits, and writing 1s to a trigger-clear word (base NUM_SRC+W) clears them. Reading either word returns the current trigger bits.
- R4: A line-state word (base NUM_SRC+4W) reads the raw hardware lines, and writes to it change nothing.
- R5: The routing word of source s sits at address s, and its bit n routes the source to CPU n. Only bits 0 to NUM_CPU-1 are stored; the other bits read back as 0.
- R6: The event word of a CPU is {16'h0001, source number} for the lowest-numbered pending, unmasked source routed to it. It is 32'h0 when there is none.
- R7: A source returned to a CPU that pulses its acknowledge strobe is masked at that clock edge. This takes precedence over a mask-clear write to the same source in the same cycle.
- R8: irq_o[n] is high, without a clock delay, whenever at least one pending, unmasked source is routed to CPU n.
- R9: When several CPUs acknowledge in the same cycle and would get the same source, the lowest-numbered CPU gets it. Each later CPU receives its next eligible source instead.
- R10: After reset every mask bit is 1, every trigger bit is 0, every routing word is 1 (CPU 0 only), and no irq_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_irq | input | NUM_SRC | Level interrupt lines, one per source |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe, 0 otherwise |
| evt_rd | input | NUM_CPU | Per-CPU acknowledge strobe |
| evt_data | output | 32*NUM_CPU | Per-CPU event word; CPU n uses bits [32n+31:32n] |
| irq_o | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The hardest situation to reach is a collision. Two processors acknowledge in the same cycle while both are eligible for the same lowest source, and a mask-clear write may land on the source being taken in that very cycle. Directed steps route two sources to both processors and pulse both strobes together. Another step aims a mask-clear write at the source being acknowledged. A long random phase then drives sparse line changes, random register traffic and both strobes at random, while a behavioural model judges every cycle.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// irqc_pkg: shared types and helpers for the interrupt controller.
// Assumes 32-bit register words and at most 65536 sources.
package irqc_pkg;

    localparam logic [15:0] EVT_KIND_HW = 16'h0001;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_ROUTE,
        RG_TRIG_SET,
        RG_TRIG_CLR,
        RG_MASK_SET,
        RG_MASK_CLR,
        RG_LINES
    } region_e;

    // Build an event word from a found flag and a source number.
    function automatic logic [31:0] make_event(input logic found, input logic [15:0] src);
        return found ? {EVT_KIND_HW, src} : 32'h0;
    endfunction

endpackage

// File: rtl/irqc_prio_enc.sv
`timescale 1ns/1ps
// irqc_prio_enc: finds the lowest set bit of a vector.
// Assumes N >= 2. idx is 0 when found is low.
module irqc_prio_enc #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
// irqc_regs: register file of the interrupt controller. It holds the
// trigger, mask and routing state and decodes the word-addressed port.
// Assumes NUM_SRC is a multiple of 32 and the map fits in ADDR_W bits.
// The acknowledge mask from the arbiter overrides a same-cycle mask clear.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    parameter int ADDR_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0]                hw_irq,
    input  logic                              bus_sel,
    input  logic                              bus_we,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    input  logic [NUM_SRC-1:0]                ack_mask,
    output logic [NUM_SRC-1:0]                mask_q,
    output logic [NUM_SRC-1:0]                sw_q,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_q
);

    localparam int WORDS    = NUM_SRC / 32;
    localparam int ARR_BASE = NUM_SRC;
    localparam int ARR_END  = ARR_BASE + 5 * WORDS;
    localparam int SRC_W    = $clog2(NUM_SRC);

    region_e            region;
    logic [31:0]        addr32;
    logic [31:0]        rel;
    logic [31:0]        grp;
    logic [31:0]        word;
    logic [SRC_W-1:0]   src_idx;
    logic [NUM_SRC-1:0] trig_set, trig_clr, msk_set, msk_clr;
    logic               wr_en;

    assign wr_en   = bus_sel && bus_we;
    assign src_idx = addr32[SRC_W-1:0];

    // Split the word address into a region and a word index within it.
    always_comb begin
        addr32 = 32'(bus_addr);
        rel    = addr32 - 32'(ARR_BASE);
        grp    = rel / 32'(WORDS);
        word   = rel - grp * 32'(WORDS);
        region = RG_NONE;
        if (addr32 < 32'(NUM_SRC)) begin
            region = RG_ROUTE;
        end else if (addr32 < 32'(ARR_END)) begin
            case (grp)
                32'd0:   region = RG_TRIG_SET;
                32'd1:   region = RG_TRIG_CLR;
                32'd2:   region = RG_MASK_SET;
                32'd3:   region = RG_MASK_CLR;
                default: region = RG_LINES;
            endcase
        end
    end

    // Spread a write to an array word over the per-source set/clear vectors.
    always_comb begin
        trig_set = '0;
        trig_clr = '0;
        msk_set  = '0;
        msk_clr  = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (wr_en && word == 32'(k)) begin
                case (region)
                    RG_TRIG_SET: trig_set[k*32 +: 32] = bus_wdata;
                    RG_TRIG_CLR: trig_clr[k*32 +: 32] = bus_wdata;
                    RG_MASK_SET: msk_set[k*32 +: 32]  = bus_wdata;
                    RG_MASK_CLR: msk_clr[k*32 +: 32]  = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Trigger bits: set, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= (sw_q | trig_set) & ~trig_clr;
    end

    // Mask bits: set, then clear, then acknowledge masking wins.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= ((mask_q | msk_set) & ~msk_clr) | ack_mask;
    end

    // One routing word per source; only the CPU bits are kept.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[s] <= NUM_CPU'(1);
            else if (wr_en && region == RG_ROUTE && src_idx == SRC_W'(s))
                route_q[s] <= bus_wdata[NUM_CPU-1:0];
        end
    end

    // Read data, same cycle as the read strobe.
    always_comb begin
        bus_rdata = 32'h0;
        if (bus_sel && !bus_we) begin
            if (region == RG_ROUTE) begin
                bus_rdata = 32'(route_q[src_idx]);
            end else begin
                for (int k = 0; k < WORDS; k++) begin
                    if (word == 32'(k)) begin
                        case (region)
                            RG_TRIG_SET, RG_TRIG_CLR: bus_rdata = sw_q[k*32 +: 32];
                            RG_MASK_SET, RG_MASK_CLR: bus_rdata = mask_q[k*32 +: 32];
                            RG_LINES:                 bus_rdata = hw_irq[k*32 +: 32];
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irqc_arbiter.sv
`timescale 1ns/1ps
// irqc_arbiter: per-CPU selection of the lowest eligible source.
// Sources claimed by a lower-numbered acknowledging CPU are hidden from
// the higher-numbered CPUs in the same cycle. Purely combinational.
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2
) (
    input  logic [NUM_SRC-1:0]              pending,
    input  logic [NUM_SRC-1:0]              mask_q,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q,
    input  logic [NUM_CPU-1:0]              evt_rd,
    output logic [32*NUM_CPU-1:0]           evt_data,
    output logic [NUM_CPU-1:0]              irq_o,
    output logic [NUM_SRC-1:0]              ack_mask
);

    localparam int SRC_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] claimed [NUM_CPU+1];

    assign claimed[0] = '0;
    assign ack_mask   = claimed[NUM_CPU];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_SRC-1:0] column;
        logic [NUM_SRC-1:0] eligible;
        logic [NUM_SRC-1:0] cand;
        logic [NUM_SRC-1:0] grant;
        logic               found;
        logic [SRC_W-1:0]   idx;

        // Gather the routing bit of this CPU from every source.
        always_comb begin
            for (int s = 0; s < NUM_SRC; s++) column[s] = route_q[s][c];
        end

        assign eligible = pending & ~mask_q & column;
        assign cand     = eligible & ~claimed[c];

        irqc_prio_enc #(.N(NUM_SRC), .IDX_W(SRC_W)) u_enc (
            .vec   (cand),
            .found (found),
            .idx   (idx)
        );

        assign grant          = found ? (NUM_SRC'(1) << idx) : '0;
        assign claimed[c + 1] = claimed[c] | (evt_rd[c] ? grant : '0);
        assign irq_o[c]       = |eligible;
        assign evt_data[c*32 +: 32] = make_event(found, 16'(idx));
    end

endmodule

// File: rtl/irqc_ctrl.sv
`timescale 1ns/1ps
// irqc_ctrl: top of the multi-CPU auto-masking interrupt controller.
// Pending = hardware line OR software trigger; an acknowledge strobe
// returns the lowest eligible source and masks it at the same edge.
module irqc_ctrl #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    parameter int ADDR_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      hw_irq,
    input  logic                    bus_sel,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_CPU-1:0]      evt_rd,
    output logic [32*NUM_CPU-1:0]   evt_data,
    output logic [NUM_CPU-1:0]      irq_o
);

    logic [NUM_SRC-1:0]              mask_q;
    logic [NUM_SRC-1:0]              sw_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;
    logic [NUM_SRC-1:0]              ack_mask;
    logic [NUM_SRC-1:0]              pending;

    // Level pending: line or software trigger.
    assign pending = hw_irq | sw_q;

    irqc_regs #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_irq    (hw_irq),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ack_mask  (ack_mask),
        .mask_q    (mask_q),
        .sw_q      (sw_q),
        .route_q   (route_q)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_arb (
        .pending  (pending),
        .mask_q   (mask_q),
        .route_q  (route_q),
        .evt_rd   (evt_rd),
        .evt_data (evt_data),
        .irq_o    (irq_o),
        .ack_mask (ack_mask)
    );

endmodule

// File: rtl/irqc_ctrl_checker.sv
`timescale 1ns/1ps
// irqc_ctrl_checker: temporal properties of irqc_ctrl, bound to the top.
module irqc_ctrl_checker #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_SRC-1:0]    hw_irq,
    input logic [NUM_CPU-1:0]    evt_rd,
    input logic [32*NUM_CPU-1:0] evt_data,
    input logic [NUM_CPU-1:0]    irq_o,
    input logic [NUM_SRC-1:0]    mask_q,
    input logic [NUM_SRC-1:0]    sw_q
);

    localparam int SRC_W = $clog2(NUM_SRC);

    // R10: one cycle after a reset cycle everything is masked and untriggered.
    assert_reset_state_R10: assert property (@(posedge clk)
        !rst_n |=> ((&mask_q) && (sw_q == '0)))
        else $error("reset state violated");

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        // R7: an acknowledged source is masked on the next cycle.
        assert_automask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_rd[c] && evt_data[c*32+16]) |=> mask_q[$past(evt_data[c*32 +: SRC_W])])
            else $error("acknowledged source not masked");

        // R6: a reported source is pending and unmasked.
        assert_event_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
            evt_data[c*32+16] |-> (!mask_q[evt_data[c*32 +: SRC_W]] &&
                (hw_irq[evt_data[c*32 +: SRC_W]] || sw_q[evt_data[c*32 +: SRC_W]])))
            else $error("event names an ineligible source");

        // R8: a valid event implies the CPU's request is raised.
        assert_irq_with_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
            evt_data[c*32+16] |-> irq_o[c])
            else $error("event without irq");
    end

    if (NUM_CPU >= 2) begin : g_pair
        // R9: two same-cycle acknowledges never receive the same source.
        assert_no_double_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_rd[0] && evt_rd[1] && evt_data[16] && evt_data[48])
                |-> (evt_data[15:0] != evt_data[47:32]))
            else $error("same source granted twice");
    end

endmodule

bind irqc_ctrl irqc_ctrl_checker #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_irq   (hw_irq),
    .evt_rd   (evt_rd),
    .evt_data (evt_data),
    .irq_o    (irq_o),
    .mask_q   (mask_q),
    .sw_q     (sw_q)
);

// File: tb/irqc_ctrl_test.sv
`timescale 1ns/1ps
module irqc_ctrl_test;

    localparam int NS = 64;
    localparam int NC = 2;
    localparam int AW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     hw_irq = '0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NC-1:0]     evt_rd = '0;
    logic [32*NC-1:0]  evt_data;
    logic [NC-1:0]     irq_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // behavioural reference state
    logic [NS-1:0] m_mask;
    logic [NS-1:0] m_sw;
    logic [31:0]   m_route [NS];
    logic [NS-1:0] m_ack;
    logic [31:0]   exp_evt [NC];
    logic [NC-1:0] exp_irq;

    always #2.5 clk = ~clk;

    irqc_ctrl #(.NUM_SRC(NS), .NUM_CPU(NC), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_rd(evt_rd), .evt_data(evt_data), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected events, requests and acknowledge set from the model.
    task automatic model_eval();
        logic [NS-1:0] taken = '0;
        exp_irq = '0;
        for (int c = 0; c < NC; c++) begin
            int pick = -1;
            for (int s = 0; s < NS; s++) begin
                if ((hw_irq[s] || m_sw[s]) && !m_mask[s] && m_route[s][c]) begin
                    exp_irq[c] = 1'b1;
                    if (pick < 0 && !taken[s]) pick = s;
                end
            end
            exp_evt[c] = (pick < 0) ? 32'h0 : (32'h0001_0000 | 32'(pick));
            if (evt_rd[c] && pick >= 0) taken[pick] = 1'b1;
        end
        m_ack = taken;
    endtask

    function automatic logic [31:0] model_read();
        int a = int'(bus_addr);
        int grp, w;
        logic [31:0] r = 32'h0;
        if (!bus_sel || bus_we) return 32'h0;
        if (a < NS) return m_route[a];
        if (a >= NS + 5 * (NS / 32)) return 32'h0;
        grp = (a - NS) / (NS / 32);
        w = (a - NS) % (NS / 32);
        for (int b = 0; b < 32; b++) begin
            case (grp)
                0, 1:    r[b] = m_sw[32*w + b];
                2, 3:    r[b] = m_mask[32*w + b];
                default: r[b] = hw_irq[32*w + b];
            endcase
        end
        return r;
    endfunction

    task automatic model_update();
        int a = int'(bus_addr);
        if (bus_sel && bus_we) begin
            if (a < NS) begin
                m_route[a] = bus_wdata & 32'((1 << NC) - 1);
            end else if (a < NS + 5 * (NS / 32)) begin
                int grp = (a - NS) / (NS / 32);
                int w = (a - NS) % (NS / 32);
                for (int b = 0; b < 32; b++) begin
                    if (bus_wdata[b]) begin
                        case (grp)
                            0: m_sw[32*w + b] = 1'b1;
                            1: m_sw[32*w + b] = 1'b0;
                            2: m_mask[32*w + b] = 1'b1;
                            3: m_mask[32*w + b] = 1'b0;
                            default: ;
                        endcase
                    end
                end
            end
        end
        m_mask = m_mask | m_ack;
    endtask

    // Let inputs settle, then compare every output with the model.
    task automatic settle();
        #1;
        model_eval();
        check("R8 irq_o", 32'(irq_o), 32'(exp_irq));
        for (int c = 0; c < NC; c++) check("R6 evt_data", evt_data[c*32 +: 32], exp_evt[c]);
        check("R2 bus_rdata", bus_rdata, model_read());
    endtask

    // Advance one clock and update the model; ends at the falling edge.
    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        bus_sel = 1'b0;
        bus_we = 1'b0;
        evt_rd = '0;
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
        settle();
        tick();
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(addr);
        settle();
        data = bus_rdata;
        tick();
    endtask

    task automatic ack(input logic [NC-1:0] who, output logic [31:0] e0, output logic [31:0] e1);
        evt_rd = who;
        settle();
        e0 = evt_data[31:0];
        e1 = evt_data[63:32];
        tick();
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R6 watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, e0, e1;
        @(negedge clk);
        repeat (3) @(negedge clk);
        m_mask = '1; m_sw = '0; m_ack = '0;
        for (int s = 0; s < NS; s++) m_route[s] = 32'h1;
        rst_n = 1'b1;

        // R10: reset state
        settle();
        check("R10 irq after reset", 32'(irq_o), 32'h0);
        rd(68, v); check("R10 mask word", v, 32'hFFFF_FFFF);
        rd(64, v); check("R10 trigger word", v, 32'h0);
        rd(5, v);  check("R10 routing word", v, 32'h1);

        // R2: unmask everything
        wr(70, 32'hFFFF_FFFF);
        wr(71, 32'hFFFF_FFFF);
        rd(70, v); check("R2 mask cleared", v, 32'h0);

        // R1, R6, R7, R8: hardware lines 3 and 40
        hw_irq[3] = 1'b1; hw_irq[40] = 1'b1;
        settle();
        check("R8 irq cpu0 only", 32'(irq_o), 32'h1);
        ack(2'b01, e0, e1); check("R6 lowest source", e0, 32'h0001_0003);
        rd(68, v); check("R7 auto-masked", v, 32'h0000_0008);
        ack(2'b01, e0, e1); check("R6 next source", e0, 32'h0001_0028);
        settle();
        check("R8 irq drops when all masked", 32'(irq_o), 32'h0);
        hw_irq = '0;

        // R3, R5: software trigger on source 7, routed to CPU 1
        wr(64, 32'h80);
        wr(7, 32'h2);
        settle();
        check("R3 trigger raises cpu1", 32'(irq_o), 32'h2);
        ack(2'b10, e0, e1); check("R5 routed event", e1, 32'h0001_0007);
        wr(66, 32'h80);
        wr(70, 32'h80);
        rd(64, v); check("R3 trigger cleared", v, 32'h0);
        settle();
        check("R1 no pending after clear", 32'(irq_o), 32'h0);

        // R4: raw line readback; writes ignored
        hw_irq = 64'hA5A5_0000_0000_1200;
        rd(72, v); check("R4 lines low word", v, 32'h0000_1200);
        wr(73, 32'h0);
        rd(73, v); check("R4 write ignored", v, 32'hA5A5_0000);
        hw_irq = '0;
        wr(68, 32'h0000_1200);

        // R5: only CPU bits stored
        wr(9, 32'hFFFF_FFFF);
        rd(9, v); check("R5 routing width", v, 32'h3);

        // R9: simultaneous acknowledge
        wr(10, 32'h3);
        wr(20, 32'h3);
        hw_irq[10] = 1'b1; hw_irq[20] = 1'b1;
        ack(2'b11, e0, e1);
        check("R9 cpu0 gets lowest", e0, 32'h0001_000A);
        check("R9 cpu1 gets next", e1, 32'h0001_0014);
        hw_irq = '0;

        // R7: acknowledge beats same-cycle mask clear (mask bits 9 and 12 were set above)
        hw_irq[12] = 1'b1;
        wr(70, 32'h1000);
        evt_rd = 2'b01;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(70); bus_wdata = 32'h1000;
        settle();
        check("R7 event during clear", evt_data[31:0], 32'h0001_000C);
        tick();
        rd(68, v); check("R7 mask wins", v, 32'h0010_1608);
        hw_irq = '0;

        // R6: nothing eligible
        ack(2'b11, e0, e1);
        check("R6 empty cpu0", e0, 32'h0);
        check("R6 empty cpu1", e1, 32'h0);

        // R2: mask-set on upper word
        wr(69, 32'h1);
        rd(69, v); check("R2 mask set upper", v, 32'h0000_0101);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) hw_irq[$urandom_range(0, NS - 1)] ^= 1'b1;
            evt_rd = NC'($urandom_range(0, 3));
            if ($urandom_range(0, 2) == 0) begin
                int r = $urandom_range(0, 9);
                bus_sel = 1'b1;
                bus_we = ($urandom_range(0, 1) == 1);
                bus_addr = (r < 3) ? AW'($urandom_range(0, NS - 1)) : AW'(NS + $urandom_range(0, 11));
                bus_wdata = (r == 9) ? 32'hFFFF_FFFF : $urandom();
            end
            settle();
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule